// File: doc/BRIEF.md
# Multi-Mode Preloadable Position Counter

This block keeps a 24-bit position count for a motion axis. A quadrature decoder in front of it supplies a count-enable strobe and a direction level, and the block moves the count by one on each enabled clock. The count can use plain binary or six packed decimal digits. When it passes its end of range it either wraps or, in divide-by-N mode, reloads from a preset value. That preset value also serves as the equality reference for a compare-match event.

Carry, borrow and match events drive two shared event pins. A single 2-bit select sets both pins at once. It picks one of four options: active-low pulses, toggle flip-flops, active-high pulses, or the match signal in both polarities. A status byte collects the three toggles, a sign flag and the last direction. Command strobes clear the counter, load the preset, clear the compare toggle, or perform a master reset. A mode write strobe captures the coding, wrap and output-select settings.

Top module: `pos_counter`

## Requirements
- R1: In binary mode (mode bit bcd=0), each clock with `cnt_en`=1 adds one to `count` when `cnt_up`=1 and subtracts one when `cnt_up`=0. Counting up from 24'hFFFFFF raises a carry, counting down from 0 raises a borrow, and in both cases the count wraps. With `cnt_en`=0 and no command, `count` holds.
- R2: In BCD mode (bcd=1), each 4-bit nibble of `count` is one decimal digit. Counting up from 24'h999999 gives 24'h000000 with a carry. Counting down from 24'h000000 gives 24'h999999 with a borrow.
- R3: In divide-by-N mode (divn=1), a count step that raises a carry or a borrow loads `preset` into the counter in place of the wrapped value.
- R4: A carry or borrow appears as an internal pulse lasting one clock, aligned with the counter update. The carry toggle (status bit 1) and the borrow toggle (status bit 0) each invert one clock after their pulse.
- R5: The output select `mode_osel` sets both event pins. With 00, `evt_a` is the inverted carry pulse and `evt_b` is the inverted borrow pulse. With 01, they are the carry toggle and the borrow toggle. With 10, they are the carry pulse and the borrow pulse. With 11, `evt_a` is the inverted match pulse and `evt_b` is the match pulse.
- R6: The match pulse lasts one clock. It is raised on the clock after a count step leaves `count` equal to `preset`. The compare toggle (status bit 2) inverts one clock after the match pulse. `cmd_clr_cmp` clears the compare toggle, and no other command except master reset changes it.
- R7: `status` is {3'b111, direction, sign, compare toggle, carry toggle, borrow toggle}, listed from bit 7 down to bit 0.
- R8: A carry sets the sign bit (status bit 3) and a borrow clears it. The direction bit (status bit 4) takes the value of `cnt_up` on each clock with `cnt_en`=1.
- R9: `cmd_clr_cnt` sets the counter to zero, clears the carry and borrow toggles and sets the sign bit.
- R10: `cmd_load` copies `preset` into the counter. When strobes coincide, master reset wins over counter clear, counter clear wins over load, and load wins over a count step.
- R11: `rst` or `cmd_master` sets the counter to exactly zero. It also clears all toggles, pulses, the direction bit and the mode register, and sets the sign bit.
- R12: `mode_wr` captures `mode_bcd`, `mode_divn` and `mode_osel`. The new mode applies from the next clock, and the mode holds while `mode_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count strobe from the decoder |
| cnt_up | input | 1 | Count direction, 1 = up |
| preset | input | 24 | Preset, reload and compare value |
| mode_wr | input | 1 | Mode capture strobe |
| mode_bcd | input | 1 | 1 = BCD coding |
| mode_divn | input | 1 | 1 = reload on carry or borrow |
| mode_osel | input | 2 | Event pin select |
| cmd_clr_cnt | input | 1 | Clear counter, carry/borrow toggles, set sign |
| cmd_load | input | 1 | Load preset into counter |
| cmd_clr_cmp | input | 1 | Clear compare toggle |
| cmd_master | input | 1 | Master reset |
| count | output | 24 | Current counter value |
| evt_a | output | 1 | Event pin A |
| evt_b | output | 1 | Event pin B |
| status | output | 8 | Status byte |

## Verification
A wrong next-count in either coding is visible on `count` on the very clock after the step. A missed carry or borrow is visible on the event pins in that same clock when a pulse select is active, and in the toggle bits of `status` one clock later. A stale or extra match is visible two clocks after the arriving step: first as the match pin level under select 11, and then as a flip of status bit 2. Because every output is compared on every clock, a fault shows up within at most two clocks of the event that caused it.

// File: rtl/pos_counter_pkg.sv
package pos_counter_pkg;

    typedef enum logic [1:0] {
        OSEL_LOW   = 2'b00,
        OSEL_TGL   = 2'b01,
        OSEL_HIGH  = 2'b10,
        OSEL_MATCH = 2'b11
    } osel_e;

    typedef struct packed {
        logic  bcd;
        logic  divn;
        osel_e osel;
    } mode_t;

    localparam mode_t MODE_RESET = '{bcd: 1'b0, divn: 1'b0, osel: OSEL_LOW};

    typedef struct packed {
        logic cmp_tgl;
        logic carry_tgl;
        logic borrow_tgl;
    } tgl_t;

    function automatic logic [7:0] pack_status(input logic dir, input logic sign, input tgl_t t);
        return {3'b111, dir, sign, t.cmp_tgl, t.carry_tgl, t.borrow_tgl};
    endfunction

endpackage

// File: rtl/pc_step.sv
module pc_step #(
    parameter int W = 24
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] preset,
    input  logic         up,
    input  logic         bcd,
    input  logic         divn,
    output logic [W-1:0] nxt,
    output logic         carry,
    output logic         borrow
);
    localparam int DIG = W / 4;

    logic [DIG:0]   inc_c;
    logic [DIG:0]   dec_c;
    logic [W-1:0]   bcd_inc;
    logic [W-1:0]   bcd_dec;

    assign inc_c[0] = 1'b1;
    assign dec_c[0] = 1'b1;

    for (genvar i = 0; i < DIG; i++) begin : g_digit
        logic [3:0] d;
        assign d = cnt[4*i +: 4];
        assign bcd_inc[4*i +: 4] = !inc_c[i] ? d : (d == 4'd9 ? 4'd0 : d + 4'd1);
        assign bcd_dec[4*i +: 4] = !dec_c[i] ? d : (d == 4'd0 ? 4'd9 : d - 4'd1);
        assign inc_c[i+1] = inc_c[i] && (d == 4'd9);
        assign dec_c[i+1] = dec_c[i] && (d == 4'd0);
    end

    logic [W-1:0] stepped;
    logic         at_top;

    always_comb begin
        at_top  = bcd ? inc_c[DIG] : (&cnt);
        carry   = up && at_top;
        borrow  = !up && (cnt == '0);
        if (bcd) stepped = up ? bcd_inc : bcd_dec;
        else     stepped = up ? cnt + 1'b1 : cnt - 1'b1;
        nxt = (divn && (carry || borrow)) ? preset : stepped;
    end

endmodule

// File: rtl/pc_events.sv
module pc_events
    import pos_counter_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_cnt,
    input  logic         clr_cmp,
    input  logic         carry_in,
    input  logic         borrow_in,
    input  logic         step_in,
    input  logic [W-1:0] count,
    input  logic [W-1:0] preset,
    input  osel_e        osel,
    output logic         carry_q,
    output logic         borrow_q,
    output logic         match_q,
    output tgl_t         tgl,
    output logic         sign,
    output logic         evt_a,
    output logic         evt_b
);
    logic step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q  <= 1'b0;
            borrow_q <= 1'b0;
            match_q  <= 1'b0;
            step_q   <= 1'b0;
            tgl      <= '0;
            sign     <= 1'b1;
        end else begin
            carry_q  <= carry_in;
            borrow_q <= borrow_in;
            step_q   <= step_in;
            match_q  <= step_q && (count == preset);
            tgl.carry_tgl  <= clr_cnt ? 1'b0 : tgl.carry_tgl ^ carry_q;
            tgl.borrow_tgl <= clr_cnt ? 1'b0 : tgl.borrow_tgl ^ borrow_q;
            tgl.cmp_tgl    <= clr_cmp ? 1'b0 : tgl.cmp_tgl ^ match_q;
            if (clr_cnt || carry_in) sign <= 1'b1;
            else if (borrow_in)      sign <= 1'b0;
        end
    end

    always_comb begin
        unique case (osel)
            OSEL_LOW:   begin evt_a = ~carry_q;       evt_b = ~borrow_q;       end
            OSEL_TGL:   begin evt_a = tgl.carry_tgl;  evt_b = tgl.borrow_tgl;  end
            OSEL_HIGH:  begin evt_a = carry_q;        evt_b = borrow_q;        end
            default:    begin evt_a = ~match_q;       evt_b = match_q;         end
        endcase
    end

endmodule

// File: rtl/pos_counter.sv
module pos_counter
    import pos_counter_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic         cnt_up,
    input  logic [W-1:0] preset,
    input  logic         mode_wr,
    input  logic         mode_bcd,
    input  logic         mode_divn,
    input  logic [1:0]   mode_osel,
    input  logic         cmd_clr_cnt,
    input  logic         cmd_load,
    input  logic         cmd_clr_cmp,
    input  logic         cmd_master,
    output logic [W-1:0] count,
    output logic         evt_a,
    output logic         evt_b,
    output logic [7:0]   status
);
    logic         hard_rst;
    mode_t        mode_q;
    logic         dir_q;
    logic [W-1:0] nxt;
    logic         st_carry;
    logic         st_borrow;
    logic         do_step;
    logic         ev_carry;
    logic         ev_borrow;
    logic         ev_match;
    tgl_t         tgl;
    logic         sign;

    assign hard_rst = rst || cmd_master;
    assign do_step  = cnt_en && !cmd_clr_cnt && !cmd_load;

    always_ff @(posedge clk) begin
        if (hard_rst) begin
            mode_q <= MODE_RESET;
            dir_q  <= 1'b0;
            count  <= '0;
        end else begin
            if (mode_wr) mode_q <= '{bcd: mode_bcd, divn: mode_divn, osel: osel_e'(mode_osel)};
            if (cnt_en)  dir_q  <= cnt_up;
            if (cmd_clr_cnt)   count <= '0;
            else if (cmd_load) count <= preset;
            else if (cnt_en)   count <= nxt;
        end
    end

    pc_step #(.W(W)) u_step (
        .cnt    (count),
        .preset (preset),
        .up     (cnt_up),
        .bcd    (mode_q.bcd),
        .divn   (mode_q.divn),
        .nxt    (nxt),
        .carry  (st_carry),
        .borrow (st_borrow)
    );

    pc_events #(.W(W)) u_events (
        .clk       (clk),
        .rst       (hard_rst),
        .clr_cnt   (cmd_clr_cnt),
        .clr_cmp   (cmd_clr_cmp),
        .carry_in  (do_step && st_carry),
        .borrow_in (do_step && st_borrow),
        .step_in   (do_step),
        .count     (count),
        .preset    (preset),
        .osel      (mode_q.osel),
        .carry_q   (ev_carry),
        .borrow_q  (ev_borrow),
        .match_q   (ev_match),
        .tgl       (tgl),
        .sign      (sign),
        .evt_a     (evt_a),
        .evt_b     (evt_b)
    );

    assign status = pack_status(dir_q, sign, tgl);

endmodule

// File: rtl/pos_counter_chk.sv
module pos_counter_chk #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst,
    input logic         cnt_en,
    input logic         cnt_up,
    input logic [W-1:0] preset,
    input logic         cmd_clr_cnt,
    input logic         cmd_load,
    input logic         cmd_clr_cmp,
    input logic         cmd_master,
    input logic [W-1:0] count,
    input logic [7:0]   status,
    input logic         ev_carry,
    input logic         ev_match
);
    // R7: fixed upper bits of the status byte
    p_status_ones_r7: assert property (@(posedge clk) disable iff (rst)
        status[7:5] == 3'b111);

    // R9: counter clear result
    p_clear_cnt_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_clr_cnt && !cmd_master |=> count == '0 && status[3] && status[1:0] == 2'b00);

    // R10: load copies the preset
    p_load_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_load && !cmd_clr_cnt && !cmd_master |=> count == $past(preset));

    // R1: no strobe, no change
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !cnt_en && !cmd_clr_cnt && !cmd_load && !cmd_master |=> $stable(count));

    // R4: carry toggle follows the carry pulse by one clock
    p_carry_tgl_r4: assert property (@(posedge clk) disable iff (rst)
        ev_carry && !cmd_clr_cnt && !cmd_master |=> status[1] != $past(status[1]));

    // R6: compare toggle follows the match pulse by one clock
    p_cmp_tgl_r6: assert property (@(posedge clk) disable iff (rst)
        ev_match && !cmd_clr_cmp && !cmd_master |=> status[2] != $past(status[2]));

    // R8: direction bit tracks the strobe direction
    p_dir_r8: assert property (@(posedge clk) disable iff (rst)
        cnt_en && !cmd_master |=> status[4] == $past(cnt_up));

    // R11: master reset clears the counter
    p_master_r11: assert property (@(posedge clk) disable iff (rst)
        cmd_master |=> count == '0 && status == 8'hE8);

endmodule

bind pos_counter pos_counter_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cnt_en      (cnt_en),
    .cnt_up      (cnt_up),
    .preset      (preset),
    .cmd_clr_cnt (cmd_clr_cnt),
    .cmd_load    (cmd_load),
    .cmd_clr_cmp (cmd_clr_cmp),
    .cmd_master  (cmd_master),
    .count       (count),
    .status      (status),
    .ev_carry    (ev_carry),
    .ev_match    (ev_match)
);

// File: tb/pos_counter_tb.sv
module pos_counter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 0, cnt_up = 0;
    logic [23:0] preset = '0;
    logic        mode_wr = 0, mode_bcd = 0, mode_divn = 0;
    logic [1:0]  mode_osel = 0;
    logic        cmd_clr_cnt = 0, cmd_load = 0, cmd_clr_cmp = 0, cmd_master = 0;
    logic [23:0] count;
    logic        evt_a, evt_b;
    logic [7:0]  status;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pos_counter u_dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_up(cnt_up), .preset(preset),
        .mode_wr(mode_wr), .mode_bcd(mode_bcd), .mode_divn(mode_divn), .mode_osel(mode_osel),
        .cmd_clr_cnt(cmd_clr_cnt), .cmd_load(cmd_load), .cmd_clr_cmp(cmd_clr_cmp),
        .cmd_master(cmd_master), .count(count), .evt_a(evt_a), .evt_b(evt_b), .status(status)
    );

    // reference model state
    int  m_cnt;
    bit  m_bcd, m_divn;
    int  m_osel;
    bit  m_cp, m_bp, m_mp, m_step;
    bit  m_ct, m_bt, m_mt, m_sign, m_dir;

    function automatic int dec_of(input int v);
        int r = 0;
        int w = 1;
        for (int i = 0; i < 6; i++) begin
            r += ((v >> (4*i)) & 15) * w;
            w *= 10;
        end
        return r;
    endfunction

    function automatic int bcd_of(input int v);
        int r = 0;
        for (int i = 0; i < 6; i++) begin
            r |= (v % 10) << (4*i);
            v /= 10;
        end
        return r;
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_bcd = 0; m_divn = 0; m_osel = 0;
        m_cp = 0; m_bp = 0; m_mp = 0; m_step = 0;
        m_ct = 0; m_bt = 0; m_mt = 0; m_sign = 1; m_dir = 0;
    endtask

    task automatic model_edge();
        int nc; bit cy, bw, nstep, nmatch;
        int pv;
        pv = int'(preset);
        if (rst || cmd_master) begin
            model_reset();
            return;
        end
        cy = 0; bw = 0; nstep = 0;
        nc = m_cnt;
        if (cmd_clr_cnt) nc = 0;
        else if (cmd_load) nc = pv;
        else if (cnt_en) begin
            nstep = 1;
            if (m_bcd) begin
                int d = dec_of(m_cnt);
                if (cnt_up) begin
                    if (d == 999999) begin cy = 1; d = 0; end else d++;
                end else begin
                    if (d == 0) begin bw = 1; d = 999999; end else d--;
                end
                nc = bcd_of(d);
            end else begin
                if (cnt_up) begin cy = (m_cnt == 24'hFFFFFF); nc = (m_cnt + 1) & 24'hFFFFFF; end
                else        begin bw = (m_cnt == 0);          nc = (m_cnt - 1) & 24'hFFFFFF; end
            end
            if (m_divn && (cy || bw)) nc = pv;
        end
        nmatch = m_step && (m_cnt == pv);
        m_ct = cmd_clr_cnt ? 0 : m_ct ^ m_cp;
        m_bt = cmd_clr_cnt ? 0 : m_bt ^ m_bp;
        m_mt = cmd_clr_cmp ? 0 : m_mt ^ m_mp;
        if (cmd_clr_cnt || cy) m_sign = 1;
        else if (bw) m_sign = 0;
        if (cnt_en) m_dir = cnt_up;
        if (mode_wr) begin m_bcd = mode_bcd; m_divn = mode_divn; m_osel = int'(mode_osel); end
        m_cp = cy; m_bp = bw; m_mp = nmatch; m_step = nstep;
        m_cnt = nc;
    endtask

    task automatic compare();
        logic ea, eb;
        logic [7:0] st;
        case (m_osel)
            0: begin ea = !m_cp; eb = !m_bp; end
            1: begin ea = m_ct;  eb = m_bt;  end
            2: begin ea = m_cp;  eb = m_bp;  end
            default: begin ea = !m_mp; eb = m_mp; end
        endcase
        st = {3'b111, m_dir, m_sign, m_mt, m_ct, m_bt};
        total++;
        if (count !== 24'(m_cnt)) begin
            bad++;
            $display("FAIL R1 R2 R3 R9 R10 R11 count: got %h expected %h", count, 24'(m_cnt));
        end
        total++;
        if ({evt_a, evt_b} !== {ea, eb}) begin
            bad++;
            $display("FAIL R4 R5 R6 R12 events: got %b%b expected %b%b", evt_a, evt_b, ea, eb);
        end
        total++;
        if (status !== st) begin
            bad++;
            $display("FAIL R6 R7 R8 status: got %h expected %h", status, st);
        end
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare();
            mode_wr = 0; cmd_clr_cnt = 0; cmd_load = 0; cmd_clr_cmp = 0; cmd_master = 0;
        end
    endtask

    task automatic set_mode(input bit b, input bit d, input int s);
        mode_wr = 1; mode_bcd = b; mode_divn = d; mode_osel = 2'(s);
        cyc();
    endtask

    task automatic load(input logic [23:0] v);
        preset = v; cmd_load = 1; cnt_en = 0;
        cyc();
    endtask

    task automatic run(input bit up, input int n);
        cnt_en = 1; cnt_up = up;
        cyc(n);
        cnt_en = 0;
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        cyc(3);                          // R11 reset state
        rst = 0;
        cyc();
        // R1 binary counting, R5 select 10
        set_mode(0, 0, 2);
        run(1, 5);
        run(0, 8);                       // crosses zero: borrow, R8 sign
        cyc(3);                          // hold
        load(24'hFFFFFE);                // R10
        run(1, 4);                       // carry at top, R4
        // R5 select 01 toggles
        set_mode(0, 0, 1);
        run(0, 6); run(1, 6); cyc(2);
        set_mode(0, 0, 0);               // R5 select 00
        run(0, 3); cyc(2);
        // R6 compare match with select 11
        set_mode(0, 0, 3);
        load(24'h000008);
        preset = 24'h00000A;
        run(1, 4); cyc(3);
        run(0, 3); cyc(3);
        cmd_clr_cmp = 1; cyc(2);
        // R2 BCD
        set_mode(1, 0, 2);
        load(24'h999998);
        run(1, 4); cyc(2);
        load(24'h000001);
        run(0, 4); cyc(2);
        load(24'h000109);
        run(1, 3); run(0, 4);
        // R3 divide-by-N binary and BCD
        set_mode(0, 1, 1);
        load(24'h000002); preset = 24'h000005;
        run(0, 9); cyc(2);
        load(24'hFFFFFC);
        run(1, 6); cyc(2);
        set_mode(1, 1, 2);
        load(24'h999997); preset = 24'h000050;
        run(1, 5); cyc(2);
        // R9 clear while counting, R10 priority
        cnt_en = 1; cnt_up = 0; cmd_clr_cnt = 1; cyc();
        cmd_load = 1; preset = 24'h000321; cyc();
        cmd_clr_cnt = 1; cmd_load = 1; cyc();
        cnt_en = 0; cyc();
        // R11 master reset during activity, R12 mode write ignored under master
        set_mode(0, 0, 1);
        run(0, 2);
        cnt_en = 1; cmd_master = 1; mode_wr = 1; mode_osel = 2'd3; cyc();
        cnt_en = 0; cyc(2);
        // random binary phase
        for (int k = 0; k < 600; k++) begin
            cnt_en = ($urandom % 4) != 0;
            cnt_up = ($urandom % 3) != 0;
            if ($urandom % 50 == 0) preset = 24'($urandom);
            if ($urandom % 40 == 0) begin mode_wr = 1; mode_bcd = 0; mode_divn = 1'($urandom); mode_osel = 2'($urandom); end
            cmd_load = ($urandom % 60) == 0;
            cmd_clr_cnt = ($urandom % 80) == 0;
            cmd_clr_cmp = ($urandom % 50) == 0;
            cmd_master = ($urandom % 300) == 0;
            if (k % 97 == 0) begin preset = 24'hFFFFF0 + 24'($urandom % 16); cmd_load = 1; end
            cyc();
        end
        // random BCD phase
        cnt_en = 0; cmd_clr_cnt = 1; cyc();
        set_mode(1, 0, 0);
        for (int k = 0; k < 600; k++) begin
            cnt_en = ($urandom % 4) != 0;
            cnt_up = ($urandom % 2) != 0;
            if ($urandom % 30 == 0) begin
                preset = 24'(bcd_of(($urandom % 2) ? int'($urandom % 20) : 999990 + int'($urandom % 10)));
                cmd_load = 1;
            end
            if ($urandom % 40 == 0) begin mode_wr = 1; mode_bcd = 1; mode_divn = 1'($urandom); mode_osel = 2'($urandom); end
            cmd_clr_cmp = ($urandom % 50) == 0;
            cyc();
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule